// File: doc/BRIEF.md
# Vector Prefix Trap Decision Unit

This unit sits after instruction decode and settles, for every instruction that may carry a 64-bit vector prefix, one of three outcomes. The instruction runs on the plain scalar path, it runs on the vector path, or it raises the illegal-instruction trap so that software can emulate what the hardware lacks. Its inputs are the decoded request, which covers the prefix flag, the 24-bit mode field, vector lengths, predication, element-width override, extra mode bits, the condition-record flag, the special-register access and the kind of vector-control instruction. The capability set of the implementation is fixed at build time through parameters.

The unit never traps a plain unprefixed instruction for vector reasons. A prefixed instruction whose mode field and vector state are all zero reduces to its scalar form and runs as scalar. Any other prefixed instruction is checked against the configured capabilities. When more than one reason to trap applies, only the highest-priority cause is reported. The decision is made combinationally and registered once, so the outcome appears one clock after the valid request.

Top module: `vpx_trap_unit`

## Requirements
- R1: An unprefixed instruction (`pfx_present`=0) with `op_kind`=0 and no special-register access never traps, and runs as scalar.
- R2: A prefixed instruction with `rm_field`=0 and `vstate_nz`=0 runs as scalar, whatever its other vector request flags say.
- R3: With `CAP_LOOP`=0, a prefixed non-identity instruction with `cur_vl` greater than 1 traps with cause 3. With `cur_vl` of 0 or 1 it is not trapped for length.
- R4: With `CAP_ELW`=0, a prefixed non-identity instruction that requests element-width override traps with cause 2, at any `cur_vl`.
- R5: Integer predication is accepted only on registers 3, 10 and 30. `pred_mode` 1 is single and checks `pred_reg_a`. `pred_mode` 2 is twin and checks both `pred_reg_a` and `pred_reg_b`. `pred_mode` 3 is CR-field predication and is accepted only with `CAP_CRPRED`=1. A rejected predicate traps with cause 4.
- R6: With `NUM_CR`=8, a prefixed non-identity instruction with `rc`=1 and `max_vl` above 8 traps with cause 5. With `NUM_CR`=128 this check does not apply.
- R7: Cause 1 is raised, prefixed or not, in two cases. One is a read or write of a vector-context register (numbers `SPR_BASE` to `SPR_BASE+SPR_COUNT-1`) whose bit in `SPR_IMPL_MASK` is 0. The other is an unimplemented `op_kind`: 1 is always implemented, 2 only with `CAP_LOOP`=1, and 3 only with `CAP_EXT_OPS`=1. Cause 1 is also raised for a prefixed non-identity instruction that requests a `mode_req` bit absent from `MODE_MASK`.
- R8: Only one cause is reported. The order is 1 (unimplemented), then 2 (element width), 3 (looping), 4 (predication) and 5 (CR overflow). Cause 0 means no trap.
- R9: When `trap_o` is high, `trap_vec_o` is 0x700. Otherwise it is 0.
- R10: One clock after a cycle with `in_valid` high, exactly one of `trap_o`, `exec_scalar_o` and `exec_vec_o` is high. One clock after a cycle with `in_valid` low, all three are low. A prefixed non-identity instruction that passes every check runs as vector.
- R11: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded request present |
| pfx_present | input | 1 | Instruction carries the vector prefix |
| rm_field | input | 24 | Mode field of the prefix |
| cur_vl | input | VL_W | Current vector length |
| max_vl | input | VL_W | Maximum vector length |
| vstate_nz | input | 1 | Some vector-state register is nonzero |
| ew_req | input | 1 | Element-width override requested |
| pred_mode | input | 2 | 0 none, 1 single, 2 twin, 3 CR-field |
| pred_reg_a | input | 5 | First predicate register |
| pred_reg_b | input | 5 | Second predicate register (twin) |
| mode_req | input | MODE_W | Requested extra mode bits |
| rc | input | 1 | Condition-record flag |
| op_kind | input | 2 | 0 ordinary, 1 set-length, 2 step, 3 other vector control |
| spr_access | input | 1 | Instruction reads or writes a special register |
| spr_num | input | SPR_W | Special-register number |
| trap_o | output | 1 | Illegal-instruction trap request |
| trap_vec_o | output | 12 | Trap vector offset |
| cause_o | output | 3 | Reported trap cause |
| exec_scalar_o | output | 1 | Run on the scalar path |
| exec_vec_o | output | 1 | Run on the vector path |

## Verification
Every result, whether trap, cause, vector offset or path select, is due exactly one rising edge after the request is presented. The bench therefore drives each request on a falling edge and compares the outputs at the next falling edge, after that single register stage has loaded. Because a new request goes in each cycle, the checks follow one cycle behind the drive. Two instances run side by side, one with minimal capabilities and one with full capabilities, under a sweep of the request space. The expected results come from a bench-side priority model of the requirements.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
   typedef enum logic [2:0] {
      CAUSE_NONE   = 3'd0,
      CAUSE_UNIMPL = 3'd1,
      CAUSE_ELW    = 3'd2,
      CAUSE_LOOP   = 3'd3,
      CAUSE_PRED   = 3'd4,
      CAUSE_CROVF  = 3'd5
   } cause_e;

   typedef enum logic [1:0] {
      PM_NONE   = 2'd0,
      PM_SINGLE = 2'd1,
      PM_TWIN   = 2'd2,
      PM_CRFLD  = 2'd3
   } pred_mode_e;

   typedef enum logic [1:0] {
      OPK_PLAIN  = 2'd0,
      OPK_SETLEN = 2'd1,
      OPK_STEP   = 2'd2,
      OPK_EXT    = 2'd3
   } op_kind_e;

   localparam logic [11:0] ILLEGAL_VEC = 12'h700;
   localparam int RM_W = 24;
   localparam int PREG_W = 5;
endpackage

// File: rtl/vpx_spr_decode.sv
module vpx_spr_decode #(
   parameter int SPR_W = 10,
   parameter int SPR_BASE = 720,
   parameter int SPR_COUNT = 8,
   parameter logic [SPR_COUNT-1:0] SPR_IMPL_MASK = '1
) (
   input  logic             spr_access,
   input  logic [SPR_W-1:0] spr_num,
   output logic             spr_bad
);
   logic [SPR_COUNT-1:0] slot_hit;

   for (genvar s = 0; s < SPR_COUNT; s++) begin : g_slot
      localparam logic [SPR_W-1:0] SLOT_NUM = SPR_W'(SPR_BASE + s);
      if (SPR_IMPL_MASK[s]) begin : g_impl
         assign slot_hit[s] = 1'b0;
      end else begin : g_unimpl
         assign slot_hit[s] = (spr_num == SLOT_NUM);
      end
   end

   assign spr_bad = spr_access && (|slot_hit);
endmodule

// File: rtl/vpx_pred_check.sv
module vpx_pred_check
   import vpx_pkg::*;
#(
   parameter int OK_NUM = 3,
   parameter logic [OK_NUM*PREG_W-1:0] OK_REGS = {5'd30, 5'd10, 5'd3},
   parameter bit CAP_CRPRED = 1'b0
) (
   input  logic [1:0]        pred_mode,
   input  logic [PREG_W-1:0] reg_a,
   input  logic [PREG_W-1:0] reg_b,
   output logic              pred_fail
);
   logic [OK_NUM-1:0] hit_a, hit_b;
   logic ok_a, ok_b, cr_fail;

   for (genvar i = 0; i < OK_NUM; i++) begin : g_reg
      assign hit_a[i] = (reg_a == OK_REGS[i*PREG_W +: PREG_W]);
      assign hit_b[i] = (reg_b == OK_REGS[i*PREG_W +: PREG_W]);
   end

   assign ok_a = |hit_a;
   assign ok_b = |hit_b;

   if (CAP_CRPRED) begin : g_cr_on
      assign cr_fail = 1'b0;
   end else begin : g_cr_off
      assign cr_fail = 1'b1;
   end

   always_comb begin
      unique case (pred_mode_e'(pred_mode))
         PM_NONE:   pred_fail = 1'b0;
         PM_SINGLE: pred_fail = !ok_a;
         PM_TWIN:   pred_fail = !(ok_a && ok_b);
         PM_CRFLD:  pred_fail = cr_fail;
         default:   pred_fail = 1'b1;
      endcase
   end
endmodule

// File: rtl/vpx_rule_eval.sv
module vpx_rule_eval
   import vpx_pkg::*;
#(
   parameter int VL_W = 8,
   parameter int MODE_W = 4,
   parameter bit CAP_LOOP = 1'b0,
   parameter bit CAP_ELW = 1'b0,
   parameter bit CAP_EXT_OPS = 1'b0,
   parameter int NUM_CR = 8,
   parameter logic [MODE_W-1:0] MODE_MASK = '0
) (
   input  logic              pfx_present,
   input  logic [RM_W-1:0]   rm_field,
   input  logic [VL_W-1:0]   cur_vl,
   input  logic [VL_W-1:0]   max_vl,
   input  logic              vstate_nz,
   input  logic              ew_req,
   input  logic [MODE_W-1:0] mode_req,
   input  logic              rc,
   input  logic [1:0]        op_kind,
   input  logic              spr_bad,
   input  logic              pred_fail,
   output cause_e            cause,
   output logic              vec_path
);
   localparam logic [VL_W-1:0] CR_LIMIT = VL_W'(NUM_CR);
   logic identity, op_bad, mode_bad, unimpl, elw_bad, loop_bad, pred_bad, cr_bad;
   logic step_bad, ext_bad;

   assign identity = pfx_present && (rm_field == '0) && !vstate_nz;
   assign vec_path = pfx_present && !identity;

   if (CAP_LOOP) begin : g_loop_hw
      assign loop_bad = 1'b0;
      assign step_bad = 1'b0;
   end else begin : g_loop_trap
      assign loop_bad = vec_path && (cur_vl > VL_W'(1));
      assign step_bad = 1'b1;
   end

   if (CAP_ELW) begin : g_elw_hw
      assign elw_bad = 1'b0;
   end else begin : g_elw_trap
      assign elw_bad = vec_path && ew_req;
   end

   if (CAP_EXT_OPS) begin : g_ext_hw
      assign ext_bad = 1'b0;
   end else begin : g_ext_trap
      assign ext_bad = 1'b1;
   end

   if (NUM_CR >= 128) begin : g_cr_full
      assign cr_bad = 1'b0;
   end else begin : g_cr_small
      assign cr_bad = vec_path && rc && (max_vl > CR_LIMIT);
   end

   always_comb begin
      unique case (op_kind_e'(op_kind))
         OPK_PLAIN:  op_bad = 1'b0;
         OPK_SETLEN: op_bad = 1'b0;
         OPK_STEP:   op_bad = step_bad;
         OPK_EXT:    op_bad = ext_bad;
         default:    op_bad = 1'b1;
      endcase
   end

   assign mode_bad = vec_path && |(mode_req & ~MODE_MASK);
   assign unimpl   = op_bad || spr_bad || mode_bad;
   assign pred_bad = vec_path && pred_fail;

   always_comb begin
      if (unimpl)        cause = CAUSE_UNIMPL;
      else if (elw_bad)  cause = CAUSE_ELW;
      else if (loop_bad) cause = CAUSE_LOOP;
      else if (pred_bad) cause = CAUSE_PRED;
      else if (cr_bad)   cause = CAUSE_CROVF;
      else               cause = CAUSE_NONE;
   end
endmodule

// File: rtl/vpx_trap_unit.sv
module vpx_trap_unit
   import vpx_pkg::*;
#(
   parameter int VL_W = 8,
   parameter int MODE_W = 4,
   parameter int SPR_W = 10,
   parameter int SPR_BASE = 720,
   parameter int SPR_COUNT = 8,
   parameter logic [SPR_COUNT-1:0] SPR_IMPL_MASK = 8'b0000_0011,
   parameter bit CAP_LOOP = 1'b0,
   parameter bit CAP_ELW = 1'b0,
   parameter bit CAP_CRPRED = 1'b0,
   parameter bit CAP_EXT_OPS = 1'b0,
   parameter int NUM_CR = 8,
   parameter logic [MODE_W-1:0] MODE_MASK = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              pfx_present,
   input  logic [23:0]       rm_field,
   input  logic [VL_W-1:0]   cur_vl,
   input  logic [VL_W-1:0]   max_vl,
   input  logic              vstate_nz,
   input  logic              ew_req,
   input  logic [1:0]        pred_mode,
   input  logic [4:0]        pred_reg_a,
   input  logic [4:0]        pred_reg_b,
   input  logic [MODE_W-1:0] mode_req,
   input  logic              rc,
   input  logic [1:0]        op_kind,
   input  logic              spr_access,
   input  logic [SPR_W-1:0]  spr_num,
   output logic              trap_o,
   output logic [11:0]       trap_vec_o,
   output logic [2:0]        cause_o,
   output logic              exec_scalar_o,
   output logic              exec_vec_o
);
   if (NUM_CR != 8 && NUM_CR != 128) begin : g_bad_cr
      $error("vpx_trap_unit: NUM_CR must be 8 or 128");
   end
   if (VL_W < 8) begin : g_bad_vl
      $error("vpx_trap_unit: VL_W must hold the value 128");
   end
   if (SPR_BASE + SPR_COUNT > (1 << SPR_W)) begin : g_bad_spr
      $error("vpx_trap_unit: vector SPR window exceeds SPR number space");
   end

   logic   spr_bad, pred_fail, vec_path;
   cause_e cause;

   vpx_spr_decode #(
      .SPR_W(SPR_W), .SPR_BASE(SPR_BASE), .SPR_COUNT(SPR_COUNT),
      .SPR_IMPL_MASK(SPR_IMPL_MASK)
   ) u_spr (
      .spr_access(spr_access), .spr_num(spr_num), .spr_bad(spr_bad)
   );

   vpx_pred_check #(
      .CAP_CRPRED(CAP_CRPRED)
   ) u_pred (
      .pred_mode(pred_mode), .reg_a(pred_reg_a), .reg_b(pred_reg_b),
      .pred_fail(pred_fail)
   );

   vpx_rule_eval #(
      .VL_W(VL_W), .MODE_W(MODE_W), .CAP_LOOP(CAP_LOOP), .CAP_ELW(CAP_ELW),
      .CAP_EXT_OPS(CAP_EXT_OPS), .NUM_CR(NUM_CR), .MODE_MASK(MODE_MASK)
   ) u_eval (
      .pfx_present(pfx_present), .rm_field(rm_field), .cur_vl(cur_vl),
      .max_vl(max_vl), .vstate_nz(vstate_nz), .ew_req(ew_req),
      .mode_req(mode_req), .rc(rc), .op_kind(op_kind), .spr_bad(spr_bad),
      .pred_fail(pred_fail), .cause(cause), .vec_path(vec_path)
   );

   logic trap_d;
   assign trap_d = in_valid && (cause != CAUSE_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_o        <= 1'b0;
         trap_vec_o    <= '0;
         cause_o       <= '0;
         exec_scalar_o <= 1'b0;
         exec_vec_o    <= 1'b0;
      end else begin
         trap_o        <= trap_d;
         trap_vec_o    <= trap_d ? ILLEGAL_VEC : 12'h000;
         cause_o       <= in_valid ? cause : CAUSE_NONE;
         exec_scalar_o <= in_valid && !trap_d && !vec_path;
         exec_vec_o    <= in_valid && !trap_d && vec_path;
      end
   end
endmodule

// File: rtl/vpx_trap_chk.sv
module vpx_trap_chk #(
   parameter int VL_W = 8,
   parameter bit CAP_LOOP = 1'b0,
   parameter bit CAP_ELW = 1'b0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            pfx_present,
   input logic [23:0]     rm_field,
   input logic [VL_W-1:0] cur_vl,
   input logic            vstate_nz,
   input logic            ew_req,
   input logic [1:0]      op_kind,
   input logic            spr_access,
   input logic            trap_o,
   input logic [11:0]     trap_vec_o,
   input logic            exec_scalar_o,
   input logic            exec_vec_o
);
   logic vec_req;
   assign vec_req = in_valid && pfx_present && (rm_field != '0 || vstate_nz);

   assert_plain_no_trap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !pfx_present && op_kind == 2'd0 && !spr_access) |=> (exec_scalar_o && !trap_o));

   assert_identity_scalar_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pfx_present && rm_field == '0 && !vstate_nz && op_kind == 2'd0 && !spr_access)
      |=> exec_scalar_o);

   assert_loop_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!CAP_LOOP && vec_req && cur_vl > VL_W'(1)) |=> trap_o);

   assert_elw_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!CAP_ELW && vec_req && ew_req) |=> trap_o);

   assert_trap_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trap_vec_o == (trap_o ? 12'h700 : 12'h000));

   assert_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ($countones({trap_o, exec_scalar_o, exec_vec_o}) == 1));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($countones({trap_o, exec_scalar_o, exec_vec_o}) == 0));

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R11: assert (!trap_o && !exec_scalar_o && !exec_vec_o);
      end
   end
endmodule

bind vpx_trap_unit vpx_trap_chk #(
   .VL_W(VL_W), .CAP_LOOP(CAP_LOOP), .CAP_ELW(CAP_ELW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pfx_present(pfx_present),
   .rm_field(rm_field), .cur_vl(cur_vl), .vstate_nz(vstate_nz), .ew_req(ew_req),
   .op_kind(op_kind), .spr_access(spr_access), .trap_o(trap_o),
   .trap_vec_o(trap_vec_o), .exec_scalar_o(exec_scalar_o), .exec_vec_o(exec_vec_o)
);

// File: tb/vpx_trap_unit_tb.sv
module vpx_trap_unit_tb;
   localparam int VL_W = 8;
   localparam int MODE_W = 4;
   localparam int SPR_W = 10;
   localparam int SPR_BASE = 720;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              in_valid, pfx_present, vstate_nz, ew_req, rc, spr_access;
   logic [23:0]       rm_field;
   logic [VL_W-1:0]   cur_vl, max_vl;
   logic [1:0]        pred_mode, op_kind;
   logic [4:0]        pred_reg_a, pred_reg_b;
   logic [MODE_W-1:0] mode_req;
   logic [SPR_W-1:0]  spr_num;

   logic        trap_m, sc_m, vec_m, trap_f, sc_f, vec_f;
   logic [11:0] tv_m, tv_f;
   logic [2:0]  cause_m, cause_f;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   vpx_trap_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pfx_present(pfx_present),
      .rm_field(rm_field), .cur_vl(cur_vl), .max_vl(max_vl), .vstate_nz(vstate_nz),
      .ew_req(ew_req), .pred_mode(pred_mode), .pred_reg_a(pred_reg_a),
      .pred_reg_b(pred_reg_b), .mode_req(mode_req), .rc(rc), .op_kind(op_kind),
      .spr_access(spr_access), .spr_num(spr_num), .trap_o(trap_m), .trap_vec_o(tv_m),
      .cause_o(cause_m), .exec_scalar_o(sc_m), .exec_vec_o(vec_m)
   );

   vpx_trap_unit #(
      .CAP_LOOP(1'b1), .CAP_ELW(1'b1), .CAP_CRPRED(1'b1), .CAP_EXT_OPS(1'b1),
      .NUM_CR(128), .MODE_MASK(4'b1111)
   ) u_dut_full (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pfx_present(pfx_present),
      .rm_field(rm_field), .cur_vl(cur_vl), .max_vl(max_vl), .vstate_nz(vstate_nz),
      .ew_req(ew_req), .pred_mode(pred_mode), .pred_reg_a(pred_reg_a),
      .pred_reg_b(pred_reg_b), .mode_req(mode_req), .rc(rc), .op_kind(op_kind),
      .spr_access(spr_access), .spr_num(spr_num), .trap_o(trap_f), .trap_vec_o(tv_f),
      .cause_o(cause_f), .exec_scalar_o(sc_f), .exec_vec_o(vec_f)
   );

   function automatic bit reg_ok(input logic [4:0] r);
      return (r == 5'd3) || (r == 5'd10) || (r == 5'd30);
   endfunction

   // Expected cause and path from the requirements; full selects the capable configuration.
   function automatic void model(input bit full, output int cause, output bit vpath);
      bit ident, op_bad, spr_bad, mode_bad, pred_bad;
      ident = pfx_present && rm_field == 0 && !vstate_nz;
      vpath = pfx_present && !ident;
      op_bad = (op_kind == 2) ? !full : (op_kind == 3) ? !full : 1'b0;          // R7
      spr_bad = spr_access && spr_num >= SPR_BASE && spr_num < SPR_BASE + 8
                && (spr_num - SPR_BASE) >= 2;                                     // R7 mask 0b11
      mode_bad = vpath && !full && (mode_req != 0);
      case (pred_mode)                                                            // R5
         2'd1: pred_bad = !reg_ok(pred_reg_a);
         2'd2: pred_bad = !(reg_ok(pred_reg_a) && reg_ok(pred_reg_b));
         2'd3: pred_bad = !full;
         default: pred_bad = 1'b0;
      endcase
      if (op_bad || spr_bad || mode_bad) cause = 1;                               // R8
      else if (vpath && !full && ew_req) cause = 2;                               // R4
      else if (vpath && !full && cur_vl > 1) cause = 3;                           // R3
      else if (vpath && pred_bad) cause = 4;                                      // R5
      else if (vpath && !full && rc && max_vl > 8) cause = 5;                     // R6
      else cause = 0;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic verify_one(input bit full, input int ec, input bit ev,
                             input logic t, input logic [11:0] tv, input logic [2:0] c,
                             input logic s, input logic v);
      string tag;
      tag = pfx_present ? (ec == 0 ? "R10" : "R8") : "R1";
      check({tag, " cause"}, {29'd0, c}, ec);
      check("R9 trap/vector", {19'd0, t, tv}, (ec != 0) ? 32'h1700 : 32'h0);
      check("R10 outcome", {30'd0, s, v},
            (ec != 0) ? 32'd0 : (ev ? 32'd1 : 32'd2));
   endtask

   initial begin
      int ec;
      bit ev;
      logic [7:0] vls[4];
      logic [7:0] mvls[3];
      logic [4:0] ra[3];
      logic [4:0] rb[3];
      logic [9:0] sprs[3];
      vls  = '{8'd0, 8'd1, 8'd4, 8'd9};
      mvls = '{8'd1, 8'd8, 8'd9};
      ra   = '{5'd3, 5'd30, 5'd7};
      rb   = '{5'd10, 5'd5, 5'd30};
      sprs = '{10'd0, 10'd720, 10'd725};
      in_valid = 0; pfx_present = 0; rm_field = 0; cur_vl = 0; max_vl = 0;
      vstate_nz = 0; ew_req = 0; pred_mode = 0; pred_reg_a = 0; pred_reg_b = 0;
      mode_req = 0; rc = 0; op_kind = 0; spr_access = 0; spr_num = 0;
      repeat (3) @(negedge clk);
      // R11: reset state
      check("R11 reset", {trap_m, sc_m, vec_m, tv_m, cause_m, trap_f, sc_f, vec_f}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: idle cycle gives no outcome
      check("R10 idle", {trap_m, sc_m, vec_m, trap_f, sc_f, vec_f}, 32'd0);

      for (int p = 0; p < 2; p++)
      for (int rz = 0; rz < 2; rz++)
      for (int nz = 0; nz < 2; nz++)
      for (int ew = 0; ew < 2; ew++)
      for (int vi = 0; vi < 4; vi++)
      for (int pm = 0; pm < 4; pm++)
      for (int ri = 0; ri < 3; ri++)
      for (int rcv = 0; rcv < 2; rcv++)
      for (int mi = 0; mi < 3; mi++)
      for (int op = 0; op < 4; op++)
      for (int si = 0; si < 3; si++)
      for (int md = 0; md < 2; md++) begin
         in_valid = 1; pfx_present = p[0]; rm_field = rz[0] ? 24'h000400 : 24'h0;
         vstate_nz = nz[0]; ew_req = ew[0]; cur_vl = vls[vi]; pred_mode = pm[1:0];
         pred_reg_a = ra[ri]; pred_reg_b = rb[ri]; rc = rcv[0]; max_vl = mvls[mi];
         op_kind = op[1:0]; spr_access = (si != 0); spr_num = sprs[si];
         mode_req = md[0] ? 4'b0001 : 4'b0000;
         @(negedge clk);
         model(1'b0, ec, ev);
         verify_one(1'b0, ec, ev, trap_m, tv_m, cause_m, sc_m, vec_m);
         model(1'b1, ec, ev);
         verify_one(1'b1, ec, ev, trap_f, tv_f, cause_f, sc_f, vec_f);
      end

      // Directed corners on the minimal instance
      in_valid = 1; pfx_present = 1; rm_field = 24'h000400; vstate_nz = 0; ew_req = 0;
      pred_mode = 0; rc = 0; max_vl = 1; op_kind = 0; spr_access = 0; mode_req = 0;
      cur_vl = 8'd4;
      @(negedge clk);
      check("R3 VL=4 traps", {29'd0, cause_m}, 32'd3);
      check("R10 full config runs VL=4 as vector", {31'd0, vec_f}, 32'd1);
      cur_vl = 8'd1;
      @(negedge clk);
      check("R3 VL=1 runs", {31'd0, vec_m}, 32'd1);
      ew_req = 1;
      @(negedge clk);
      check("R4 elw at VL=1 traps", {29'd0, cause_m}, 32'd2);
      ew_req = 0; rc = 1; max_vl = 8'd8;
      @(negedge clk);
      check("R6 maxvl 8 no overflow", {31'd0, trap_m}, 32'd0);
      max_vl = 8'd9;
      @(negedge clk);
      check("R6 maxvl 9 overflow", {29'd0, cause_m}, 32'd5);
      check("R6 128 CR fields absorb", {31'd0, trap_f}, 32'd0);
      pfx_present = 0; rc = 0; spr_access = 1; spr_num = 10'd727;
      @(negedge clk);
      check("R7 unprefixed spr read traps", {29'd0, cause_m}, 32'd1);
      in_valid = 0;
      @(negedge clk);
      check("R10 idle after traffic", {trap_m, sc_m, vec_m}, 32'd0);
      done = 1;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      done = 1;
   end

   initial begin
      wait (done);
      #1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule